// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port and decides when a hot-plug interrupt is signalled. Configuration writes arrive as one 32-bit dword with four byte enables. The low half is slot control and the high half is slot status. Slot-side events arrive as single-cycle requests: device insert, device remove, a cold-plug present indication and an attention-button press.

The block keeps one pending summary bit. The summary is set when the hot-plug interrupt enable is on and at least one supported event has both its status bit and its enable bit set. When the summary changes because of a control command or a newly raised event, and message interrupts are enabled, the block issues a one-cycle message request that carries the 5-bit interrupt message number. With message interrupts disabled, a level INTx line follows the summary. A hot-plug insert or remove is refused with a busy pulse while the electromechanical interlock is engaged.

All register updates take effect on the clock edge that samples the write or event strobe. The busy pulse and the message pulse appear in the cycle after that edge.

Top module: `hpslot_ctrl`

## Requirements
- R1: After reset, rdData reads 32'h0000_03C0. Control bits [9:8] (power indicator) and [7:6] (attention indicator) hold 2'b11 (off), every enable is 0, all status bits are 0, and msgReq, busy and intxLevel are low.
- R2: A write with wrBe[0] or wrBe[1] set updates only its byte of slot control. Only bits 0 (button enable), 3 (presence-change enable), 4 (command-done enable), 5 (hot-plug interrupt enable), [7:6] and [9:8] are stored. All other control bits read 0.
- R3: Any write that enables a slot-control byte is one command and sets command-completed status (status bit 4) in the same update.
- R4: Control bit 11 (interlock command) always reads 0. Writing 1 to it toggles interlock status (status bit 7).
- R5: An insert sets presence state (status bit 6) and presence-changed (status bit 3). A remove clears bit 6 and sets bit 3. When insert and remove arrive together, the insert is taken.
- R6: While interlock status is 1, an insert or remove changes nothing and produces a one-cycle busy pulse.
- R7: A cold-plug present indication sets presence state without setting presence-changed and without any interrupt.
- R8: An attention-button press sets button-pressed status (status bit 0).
- R9: Status bits 0, 3 and 4 are write-1-to-clear through byte lane wrBe[2]. Bits 6 and 7 and lane wrBe[3] clear nothing. An event raised in the same cycle as a clear of its bit leaves the bit set.
- R10: The summary is control bit 5 AND (status AND control AND 16'h0019) nonzero. intxLevel equals the summary while msiEn and msixEn are both low.
- R11: When the summary changes in a cycle that holds a control write or a newly set event bit, and msiEn or msixEn is high, msgReq pulses for one cycle. msgMsix is 1 when msixEn is high, and msgVector equals msgNum.
- R12: Raising an event whose status bit is already set changes nothing and produces no message.
- R13: A status-only write that drops the summary produces no message, and intxLevel falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Config write strobe for the slot register dword |
| wrBe | input | 4 | Byte enables: [1:0] control, [3:2] status |
| wrData | input | 32 | Write data: [15:0] control, [31:16] status |
| rdData | output | 32 | {status, control} |
| insReq | input | 1 | Hot-plug insert request |
| remReq | input | 1 | Hot-plug remove request |
| coldPresent | input | 1 | Device present at start-up |
| attnPress | input | 1 | Attention-button press |
| msiEn | input | 1 | MSI delivery enabled |
| msixEn | input | 1 | MSI-X delivery enabled (takes priority) |
| msgNum | input | 5 | Interrupt message number |
| busy | output | 1 | Insert or remove refused because the interlock is engaged |
| msgReq | output | 1 | One-cycle message interrupt request |
| msgMsix | output | 1 | Request is for MSI-X (1) or MSI (0) |
| msgVector | output | 5 | Vector carried with the request |
| intxLevel | output | 1 | Level interrupt line |

## Verification
A write-1-to-clear of a status event and a fresh raise of the same event can fall in the same cycle. The sharpest case is an attention-button press together with a status write that clears bit 0. The bench sets this up with the button interrupt enabled and the INTx path active. It then drives both in one cycle and expects the status bit to stay set and intxLevel to stay high. A later clear with no press must drop both.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;

  localparam int REG_W   = 16;
  localparam int LANE_W  = 8;
  localparam int LANES   = REG_W / LANE_W;

  // slot control bit positions
  localparam int CTL_ABPE = 0;
  localparam int CTL_PDCE = 3;
  localparam int CTL_CCIE = 4;
  localparam int CTL_HPIE = 5;
  localparam int CTL_AIND = 6;   // two bits
  localparam int CTL_PIND = 8;   // two bits
  localparam int CTL_EIC  = 11;

  // slot status bit positions
  localparam int STS_ABP = 0;
  localparam int STS_PDC = 3;
  localparam int STS_CC  = 4;
  localparam int STS_PDS = 6;
  localparam int STS_EIS = 7;

  localparam logic [1:0] IND_OFF = 2'b11;

  localparam logic [REG_W-1:0] EVT_MASK =
      (REG_W'(1) << STS_ABP) | (REG_W'(1) << STS_PDC) | (REG_W'(1) << STS_CC);

  localparam logic [REG_W-1:0] CTL_KEEP =
      (REG_W'(1) << CTL_ABPE) | (REG_W'(1) << CTL_PDCE) |
      (REG_W'(1) << CTL_CCIE) | (REG_W'(1) << CTL_HPIE) |
      (REG_W'(3) << CTL_AIND) | (REG_W'(3) << CTL_PIND);

  localparam logic [REG_W-1:0] CTL_RESET =
      (REG_W'(IND_OFF) << CTL_AIND) | (REG_W'(IND_OFF) << CTL_PIND);

  // strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] ctlLane;  // control byte lanes written
    logic             stsLane0; // status event lane written
    logic             insOk;    // accepted insert
    logic             remOk;    // accepted remove
    logic             coldSet;  // cold-plug presence
    logic             attn;     // attention press
  } hpStrobe_t;

endpackage

// File: rtl/hpslot_dp.sv
module hpslot_dp
  import hpslot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hpStrobe_t        st,
  input  logic [2*REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctlReg,
  output logic [REG_W-1:0] stsReg,
  output logic             eisNow,
  output logic             newEvt,
  output logic             nextSum
);

  logic [REG_W-1:0] ctlNext;
  logic [REG_W-1:0] stsNext;
  logic [REG_W-1:0] clrMask;
  logic [REG_W-1:0] stsCleared;
  logic [REG_W-1:0] evtSet;
  logic             eicHit;

  // per-lane control update
  always_comb begin
    ctlNext = ctlReg;
    for (int ln = 0; ln < LANES; ln++) begin
      if (st.ctlLane[ln])
        ctlNext[ln*LANE_W +: LANE_W] =
          wrData[ln*LANE_W +: LANE_W] & CTL_KEEP[ln*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    eicHit     = st.ctlLane[CTL_EIC / LANE_W] & wrData[CTL_EIC];
    clrMask    = st.stsLane0 ? (REG_W'(wrData[REG_W +: LANE_W]) & EVT_MASK) : '0;
    stsCleared = stsReg & ~clrMask;

    evtSet          = '0;
    evtSet[STS_CC]  = |st.ctlLane;
    evtSet[STS_PDC] = st.insOk | st.remOk;
    evtSet[STS_ABP] = st.attn;

    newEvt  = |(evtSet & ~stsCleared);
    stsNext = stsCleared | evtSet;
    if (st.insOk | st.coldSet) stsNext[STS_PDS] = 1'b1;
    if (st.remOk)              stsNext[STS_PDS] = 1'b0;
    if (eicHit)                stsNext[STS_EIS] = ~stsReg[STS_EIS];

    nextSum = ctlNext[CTL_HPIE] & (|(stsNext & ctlNext & EVT_MASK));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= CTL_RESET;
      stsReg <= '0;
    end else begin
      ctlReg <= ctlNext;
      stsReg <= stsNext;
    end
  end

  assign eisNow = stsReg[STS_EIS];

  // R3
  cc_on_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|st.ctlLane) |=> stsReg[STS_CC]);

  // R4
  eic_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.ctlLane[CTL_EIC / LANE_W] && wrData[CTL_EIC])
      |=> (stsReg[STS_EIS] != $past(stsReg[STS_EIS])));

  // R5
  insert_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.insOk |=> (stsReg[STS_PDS] && stsReg[STS_PDC]));

  // R7
  cold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.coldSet && !st.insOk && !st.remOk && !st.stsLane0)
      |=> (stsReg[STS_PDS] && (stsReg[STS_PDC] == $past(stsReg[STS_PDC]))));

endmodule

// File: rtl/hpslot_ctl.sv
module hpslot_ctl
  import hpslot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2*LANES-1:0] wrBe,
  input  logic             insReq,
  input  logic             remReq,
  input  logic             coldPresent,
  input  logic             attnPress,
  input  logic             msiEn,
  input  logic             msixEn,
  input  logic [VEC_W-1:0] msgNum,
  input  logic             eisNow,
  input  logic             newEvt,
  input  logic             nextSum,
  output hpStrobe_t        st,
  output logic             busy,
  output logic             msgReq,
  output logic             msgMsix,
  output logic [VEC_W-1:0] msgVector,
  output logic             intxLevel
);

  logic pendReg;
  logic cause;
  logic msgPath;
  logic refused;

  always_comb begin
    st          = '0;
    st.ctlLane  = wrEn ? wrBe[LANES-1:0] : '0;
    st.stsLane0 = wrEn & wrBe[LANES];
    st.insOk    = insReq & ~eisNow;
    st.remOk    = remReq & ~insReq & ~eisNow;
    st.coldSet  = coldPresent;
    st.attn     = attnPress;
  end

  assign refused = (insReq | remReq) & eisNow;
  assign cause   = (|st.ctlLane) | newEvt;
  assign msgPath = msiEn | msixEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg   <= 1'b0;
      busy      <= 1'b0;
      msgReq    <= 1'b0;
      msgMsix   <= 1'b0;
      msgVector <= '0;
    end else begin
      pendReg <= nextSum;
      busy    <= refused;
      msgReq  <= msgPath & cause & (nextSum != pendReg);
      if (msgPath & cause & (nextSum != pendReg)) begin
        msgMsix   <= msixEn;
        msgVector <= msgNum;
      end
    end
  end

  assign intxLevel = pendReg & ~msgPath;

  // R11
  msg_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgReq |-> (pendReg != $past(pendReg)));

  // R6
  busy_on_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((insReq || remReq) && eisNow) |=> busy);

  // R13
  silent_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cause) |=> !msgReq);

endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
  import hpslot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [3:0]       wrBe,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic             insReq,
  input  logic             remReq,
  input  logic             coldPresent,
  input  logic             attnPress,
  input  logic             msiEn,
  input  logic             msixEn,
  input  logic [VEC_W-1:0] msgNum,
  output logic             busy,
  output logic             msgReq,
  output logic             msgMsix,
  output logic [VEC_W-1:0] msgVector,
  output logic             intxLevel
);

  hpStrobe_t        st;
  logic [REG_W-1:0] ctlReg;
  logic [REG_W-1:0] stsReg;
  logic             eisNow;
  logic             newEvt;
  logic             nextSum;

  hpslot_ctl #(.VEC_W(VEC_W)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe),
    .insReq(insReq), .remReq(remReq), .coldPresent(coldPresent),
    .attnPress(attnPress), .msiEn(msiEn), .msixEn(msixEn), .msgNum(msgNum),
    .eisNow(eisNow), .newEvt(newEvt), .nextSum(nextSum), .st(st),
    .busy(busy), .msgReq(msgReq), .msgMsix(msgMsix),
    .msgVector(msgVector), .intxLevel(intxLevel)
  );

  hpslot_dp uDp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .ctlReg(ctlReg), .stsReg(stsReg), .eisNow(eisNow),
    .newEvt(newEvt), .nextSum(nextSum)
  );

  assign rdData = {stsReg, ctlReg};

endmodule

// File: tb/hpslot_ctrl_test.sv
module hpslot_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrBe = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        insReq = 1'b0, remReq = 1'b0, coldPresent = 1'b0, attnPress = 1'b0;
  logic        msiEn = 1'b0, msixEn = 1'b0;
  logic [4:0]  msgNum = '0;
  logic        busy, msgReq, msgMsix, intxLevel;
  logic [4:0]  msgVector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hpslot_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .wrData(wrData),
    .rdData(rdData), .insReq(insReq), .remReq(remReq),
    .coldPresent(coldPresent), .attnPress(attnPress), .msiEn(msiEn),
    .msixEn(msixEn), .msgNum(msgNum), .busy(busy), .msgReq(msgReq),
    .msgMsix(msgMsix), .msgVector(msgVector), .intxLevel(intxLevel)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; msiEn = 1'b0; msixEn = 1'b0; msgNum = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // drive one cycle of stimulus, then sample at the following negedge
  task automatic step(logic [3:0] be, logic [31:0] d,
                      logic ins, logic rem, logic cold, logic attn);
    @(negedge clk);
    wrEn = |be; wrBe = be; wrData = d;
    insReq = ins; remReq = rem; coldPresent = cold; attnPress = attn;
    @(negedge clk);
    wrEn = 1'b0; wrBe = '0; wrData = '0;
    insReq = 1'b0; remReq = 1'b0; coldPresent = 1'b0; attnPress = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 rdData", rdData, 32'h0000_03C0);
    chk("R1 outputs", {29'd0, msgReq, busy, intxLevel}, 32'd0);
  endtask

  task automatic testCtlWrite();
    doReset();
    step(4'b0011, 32'h0000_F7FF, 0, 0, 0, 0);
    chk("R2 R3 ctl and cc", rdData, 32'h0010_03F9);
    chk("R10 intx raised", intxLevel, 1);
    chk("R11 no msg in intx mode", msgReq, 0);
    step(4'b0001, 32'h0, 0, 0, 0, 0);
    chk("R2 low lane only", rdData, 32'h0010_0300);
    chk("R10 intx fell", intxLevel, 0);
    step(4'b0010, 32'h0, 0, 0, 0, 0);
    chk("R2 high lane only", rdData, 32'h0010_0000);
    step(4'b1000, 32'hFFFF_0000, 0, 0, 0, 0);
    chk("R9 upper status lane clears nothing", rdData, 32'h0010_0000);
    step(4'b0100, 32'h00FF_0000, 0, 0, 0, 0);
    chk("R9 w1c clears cc", rdData, 32'h0000_0000);
  endtask

  task automatic testHotplug();
    doReset();
    step(4'b0000, 32'h0, 1, 0, 0, 0);
    chk("R5 insert", rdData[31:16], 16'h0048);
    step(4'b0000, 32'h0, 0, 1, 0, 0);
    chk("R5 remove", rdData[31:16], 16'h0008);
    step(4'b0000, 32'h0, 1, 1, 0, 0);
    chk("R5 insert wins", rdData[31:16], 16'h0048);
    step(4'b0100, 32'h00FF_0000, 0, 0, 0, 0);
    chk("R9 presence kept", rdData[31:16], 16'h0040);
  endtask

  task automatic testInterlock();
    doReset();
    step(4'b0000, 32'h0, 1, 0, 0, 0);
    step(4'b0010, 32'h0000_0800, 0, 0, 0, 0);
    chk("R4 toggle on and eic reads 0", rdData, 32'h00D8_00C0);
    step(4'b0000, 32'h0, 0, 1, 0, 0);
    chk("R6 busy on remove", busy, 1);
    chk("R6 status unchanged", rdData[31:16], 16'h00D8);
    step(4'b0000, 32'h0, 1, 0, 0, 0);
    chk("R6 busy on insert", busy, 1);
    step(4'b0000, 32'h0, 0, 0, 0, 0);
    chk("R6 busy single pulse", busy, 0);
    step(4'b0010, 32'h0000_0800, 0, 0, 0, 0);
    chk("R4 toggle off", rdData[31:16], 16'h0058);
    step(4'b0000, 32'h0, 0, 1, 0, 0);
    chk("R6 remove accepted after unlock", rdData[31:16], 16'h0018);
    chk("R6 no busy", busy, 0);
  endtask

  task automatic testCold();
    doReset();
    step(4'b0001, 32'h0000_0028, 0, 0, 0, 0);
    step(4'b0000, 32'h0, 0, 0, 1, 0);
    chk("R7 cold presence", rdData[31:16], 16'h0050);
    chk("R7 no intx", intxLevel, 0);
    chk("R7 no msg", msgReq, 0);
  endtask

  task automatic testMessages();
    doReset();
    msiEn = 1'b1; msgNum = 5'd9;
    step(4'b0001, 32'h0000_0021, 0, 0, 0, 0);
    chk("R11 no change no msg", msgReq, 0);
    step(4'b0000, 32'h0, 0, 0, 0, 1);
    chk("R8 abp set", rdData[31:16], 16'h0011);
    chk("R11 msg on rise", {msgReq, msgMsix, msgVector}, {1'b1, 1'b0, 5'd9});
    step(4'b0000, 32'h0, 0, 0, 0, 1);
    chk("R12 repeat press no msg", msgReq, 0);
    chk("R12 status same", rdData[31:16], 16'h0011);
    msixEn = 1'b1; msgNum = 5'd31;
    step(4'b0001, 32'h0000_0001, 0, 0, 0, 0);
    chk("R11 msix msg on fall", {msgReq, msgMsix, msgVector}, {1'b1, 1'b1, 5'd31});
    step(4'b0001, 32'h0000_0021, 0, 0, 0, 0);
    chk("R11 msg on re-enable", msgReq, 1);
    step(4'b0100, 32'h0011_0000, 0, 0, 0, 0);
    chk("R13 silent clear", msgReq, 0);
    chk("R13 status cleared", rdData[31:16], 16'h0000);
    chk("R10 no intx in msg mode", intxLevel, 0);
  endtask

  task automatic testSameCycle();
    doReset();
    step(4'b0001, 32'h0000_0021, 0, 0, 0, 0);
    step(4'b0000, 32'h0, 0, 0, 0, 1);
    chk("R10 intx on press", intxLevel, 1);
    step(4'b0100, 32'h0001_0000, 0, 0, 0, 1);
    chk("R9 event beats clear", rdData[16], 1);
    chk("R9 intx held", intxLevel, 1);
    step(4'b0100, 32'h0001_0000, 0, 0, 0, 0);
    chk("R13 intx drops", intxLevel, 0);
    chk("R13 no msg", msgReq, 0);
  endtask

  initial begin
    testReset();
    testCtlWrite();
    testHotplug();
    testInterlock();
    testCold();
    testMessages();
    testSameCycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule